// File: doc/BRIEF.md
# Relative Branch Decoder

This block sits beside an instruction fetch stream and picks out conditional relative branches. Bytes arrive one per handshake on a valid/ready input, each with the address it was fetched from. A lone opcode in the range 0x22 to 0x2F starts a short branch that carries one offset byte. The prefix byte 0x10 followed by such an opcode starts a long branch that carries a two-byte offset. When the last offset byte has been taken, the block evaluates the branch condition against the live N, Z, V and C flags. One cycle later it reports the outcome in a single-cycle result: whether the branch is taken, the destination address, the encoded length and the cycle cost.

The input obeys valid/ready. A byte is consumed on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high except during the cycle in which a result or reject pulse is shown. A source that is stalled must hold its byte and address stable until the byte is taken. The outputs carry no back-pressure: every pulse lasts exactly one cycle. Any byte sequence that does not form a recognised branch raises `out_notbr` for one cycle, and the block returns to waiting for a fresh instruction.

Top module: `relbr_decode`

## Requirements
- R1: After reset, `out_valid` and `out_notbr` are low and `in_ready` is high. `out_valid` and `out_notbr` are never high together.
- R2: A byte of 0x22..0x2F accepted while idle begins a short branch. The next accepted byte is its offset. Result: `out_len` = 2 and `out_cycles` = 3.
- R3: Taken conditions for opcode low nibbles. 2: C=0 and Z=0. 3: C=1 or Z=1. 4: C=0. 5: C=1. 6: Z=0. 7: Z=1. 8: V=0. 9: V=1. A: N=0. B: N=1.
- R4: Signed conditions. Nibble C is taken when N equals V. Nibble D is taken when N differs from V. Nibble E is taken when Z=0 and N equals V. Nibble F is taken when Z=1 or N differs from V.
- R5: `out_target` = first instruction byte address + `out_len` + the sign-extended offset, modulo 2^16. The taken/not-taken outcome does not change it.
- R6: A prefix 0x10 accepted while idle, then a 0x22..0x2F opcode, forms a long branch. Its next two accepted bytes are the offset, high byte first. The target counts from the prefix address, and `out_len` = 4.
- R7: A long branch reports `out_cycles` = 6 when taken and 5 when not taken.
- R8: While idle, a byte that is neither 0x10 nor 0x22..0x2F gives a one-cycle `out_notbr` pulse on the next cycle and no `out_valid`. A non-branch byte after the prefix does the same. In both cases a following branch decodes normally.
- R9: The result (or reject) pulse appears on the cycle after its final byte is accepted. During that cycle `in_ready` is low, and a byte offered then is held and consumed one cycle later.
- R10: `out_valid` is high for exactly one cycle per decoded branch.
- R11: The condition uses the flag values present when the final offset byte is accepted. Earlier flag values have no effect, and neither do idle cycles between bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is offered |
| in_ready | output | 1 | Block can consume a byte this cycle |
| in_byte | input | 8 | Instruction stream byte |
| in_addr | input | 16 | Fetch address of `in_byte` |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| out_valid | output | 1 | One-cycle branch result strobe |
| out_taken | output | 1 | Branch condition holds |
| out_target | output | 16 | Destination address |
| out_len | output | 3 | Instruction length in bytes |
| out_cycles | output | 4 | Execution cycle count |
| out_notbr | output | 1 | One-cycle reject strobe for a non-branch sequence |

## Verification
A corrupted collector state shows up at the ports within one or two accepted bytes. It appears as a result arriving after the wrong number of offset bytes, a spurious reject, or a missing pulse. A wrong latched start address or offset shows only in `out_target` on the very next result pulse, so every target is compared, in both directions and across address wrap-around. A condition-table fault shows as a wrong `out_taken` value and, for long branches, as a wrong cycle count. Every opcode is therefore exercised against all sixteen flag combinations.

// File: rtl/relbr_pkg.sv
package relbr_pkg;
  localparam int ADDR_W   = 16;
  localparam int LEN_W    = 3;
  localparam int CYC_W    = 4;
  localparam logic [7:0] PREFIX_BYTE = 8'h10;
  localparam logic [LEN_W-1:0] LEN_SHORT = 3'd2;
  localparam logic [LEN_W-1:0] LEN_LONG  = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PFX,
    ST_SOFF,
    ST_LHI,
    ST_LLO
  } col_state_t;

  function automatic logic is_branch_op(input logic [7:0] b);
    return (b[7:4] == 4'h2) && (b[3:1] != 3'b000);
  endfunction
endpackage

// File: rtl/relbr_cond.sv
module relbr_cond (
  input  logic [3:0] sel,
  input  logic       n,
  input  logic       z,
  input  logic       v,
  input  logic       c,
  output logic       taken
);
  logic base;
  logic nv;

  assign nv = n ^ v;

  // Even nibble tests the base condition; odd nibble is its complement.
  always_comb begin
    case (sel[3:1])
      3'd1:    base = ~(c | z);
      3'd2:    base = ~c;
      3'd3:    base = ~z;
      3'd4:    base = ~v;
      3'd5:    base = ~n;
      3'd6:    base = ~nv;
      3'd7:    base = ~(z | nv);
      default: base = 1'b0;
    endcase
  end

  assign taken = base ^ sel[0];
endmodule

// File: rtl/relbr_collect.sv
module relbr_collect
  import relbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_ready,
  input  logic [7:0]        in_byte,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              done,
  output logic              bad,
  output logic              d_long,
  output logic [3:0]        d_sel,
  output logic [15:0]       d_off,
  output logic [ADDR_W-1:0] d_start
);
  col_state_t        state, nxt;
  logic              r_long, n_long;
  logic [3:0]        r_sel, n_sel;
  logic [ADDR_W-1:0] r_start, n_start;
  logic [7:0]        r_hi, n_hi;
  logic              accept;

  assign accept = in_valid & in_ready;

  always_comb begin
    nxt     = state;
    n_long  = r_long;
    n_sel   = r_sel;
    n_start = r_start;
    n_hi    = r_hi;
    done    = 1'b0;
    bad     = 1'b0;
    d_off   = '0;
    if (accept) begin
      case (state)
        ST_IDLE: begin
          if (in_byte == PREFIX_BYTE) begin
            n_start = in_addr;
            n_long  = 1'b1;
            nxt     = ST_PFX;
          end else if (is_branch_op(in_byte)) begin
            n_start = in_addr;
            n_long  = 1'b0;
            n_sel   = in_byte[3:0];
            nxt     = ST_SOFF;
          end else begin
            bad = 1'b1;
          end
        end
        ST_PFX: begin
          if (is_branch_op(in_byte)) begin
            n_sel = in_byte[3:0];
            nxt   = ST_LHI;
          end else begin
            bad = 1'b1;
            nxt = ST_IDLE;
          end
        end
        ST_SOFF: begin
          done  = 1'b1;
          d_off = {{8{in_byte[7]}}, in_byte};
          nxt   = ST_IDLE;
        end
        ST_LHI: begin
          n_hi = in_byte;
          nxt  = ST_LLO;
        end
        ST_LLO: begin
          done  = 1'b1;
          d_off = {r_hi, in_byte};
          nxt   = ST_IDLE;
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  assign d_long  = r_long;
  assign d_sel   = r_sel;
  assign d_start = r_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      r_long  <= 1'b0;
      r_sel   <= '0;
      r_start <= '0;
      r_hi    <= '0;
    end else begin
      state   <= nxt;
      r_long  <= n_long;
      r_sel   <= n_sel;
      r_start <= n_start;
      r_hi    <= n_hi;
    end
  end

  // R8: a rejected byte after the prefix always leaves the collector idle
  a_r8_prefix_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PFX && bad) |=> (state == ST_IDLE));

  // R2: a short branch finishes on its single offset byte
  a_r2_short_one_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SOFF && accept) |=> (state == ST_IDLE));

  // R11: the captured start address survives stall cycles
  a_r11_start_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && !accept) |=> $stable(r_start));

  // R6: the collector only reaches the offset states of a long branch through the prefix
  a_r6_long_marked: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LHI || state == ST_LLO) |-> r_long);
endmodule

// File: rtl/relbr_result.sv
module relbr_result
  import relbr_pkg::*;
#(
  parameter int CYC_SHORT   = 3,
  parameter int CYC_LONG_NT = 5,
  parameter int CYC_LONG_T  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic              bad,
  input  logic              d_long,
  input  logic [15:0]       d_off,
  input  logic [ADDR_W-1:0] d_start,
  input  logic              cond_taken,
  output logic              out_valid,
  output logic              out_notbr,
  output logic              out_taken,
  output logic [ADDR_W-1:0] out_target,
  output logic [LEN_W-1:0]  out_len,
  output logic [CYC_W-1:0]  out_cycles
);
  logic [LEN_W-1:0]  len_c;
  logic [CYC_W-1:0]  cyc_c;
  logic [ADDR_W-1:0] tgt_c;

  assign len_c = d_long ? LEN_LONG : LEN_SHORT;
  assign cyc_c = !d_long   ? CYC_W'(CYC_SHORT)
               : cond_taken ? CYC_W'(CYC_LONG_T)
               :              CYC_W'(CYC_LONG_NT);
  assign tgt_c = d_start + ADDR_W'(len_c) + d_off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_notbr  <= 1'b0;
      out_taken  <= 1'b0;
      out_target <= '0;
      out_len    <= '0;
      out_cycles <= '0;
    end else begin
      out_valid <= done;
      out_notbr <= bad;
      if (done) begin
        out_taken  <= cond_taken;
        out_target <= tgt_c;
        out_len    <= len_c;
        out_cycles <= cyc_c;
      end
    end
  end

  // R10: a result strobe never lasts two cycles
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R1: result and reject are exclusive
  a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_notbr));

  // R2: short branches carry the fixed short cost
  a_r2_short_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_len == LEN_SHORT) |-> (out_cycles == CYC_W'(CYC_SHORT)));

  // R7: a long branch costs more when taken
  a_r7_long_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_len == LEN_LONG) |-> (out_cycles == (out_taken ? CYC_W'(CYC_LONG_T) : CYC_W'(CYC_LONG_NT))));
endmodule

// File: rtl/relbr_decode.sv
module relbr_decode
  import relbr_pkg::*;
#(
  parameter int CYC_SHORT   = 3,
  parameter int CYC_LONG_NT = 5,
  parameter int CYC_LONG_T  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_byte,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic              flag_v,
  input  logic              flag_c,
  output logic              out_valid,
  output logic              out_taken,
  output logic [ADDR_W-1:0] out_target,
  output logic [LEN_W-1:0]  out_len,
  output logic [CYC_W-1:0]  out_cycles,
  output logic              out_notbr
);
  logic              done, bad, d_long, cond_taken;
  logic [3:0]        d_sel;
  logic [15:0]       d_off;
  logic [ADDR_W-1:0] d_start;

  // one bubble per reported event
  assign in_ready = ~(out_valid | out_notbr);

  relbr_collect i_collect (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_byte  (in_byte),
    .in_addr  (in_addr),
    .done     (done),
    .bad      (bad),
    .d_long   (d_long),
    .d_sel    (d_sel),
    .d_off    (d_off),
    .d_start  (d_start)
  );

  relbr_cond i_cond (
    .sel   (d_sel),
    .n     (flag_n),
    .z     (flag_z),
    .v     (flag_v),
    .c     (flag_c),
    .taken (cond_taken)
  );

  relbr_result #(
    .CYC_SHORT   (CYC_SHORT),
    .CYC_LONG_NT (CYC_LONG_NT),
    .CYC_LONG_T  (CYC_LONG_T)
  ) i_result (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (done),
    .bad        (bad),
    .d_long     (d_long),
    .d_off      (d_off),
    .d_start    (d_start),
    .cond_taken (cond_taken),
    .out_valid  (out_valid),
    .out_notbr  (out_notbr),
    .out_taken  (out_taken),
    .out_target (out_target),
    .out_len    (out_len),
    .out_cycles (out_cycles)
  );

  // R9: nothing is consumed while a strobe is shown
  a_r9_stall_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && in_valid) |=> !out_valid);
endmodule

// File: tb/test_relbr_decode.sv
`timescale 1ns/1ps
module test_relbr_decode;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_byte = '0;
  logic [15:0] in_addr = '0;
  logic        flag_n = 0, flag_z = 0, flag_v = 0, flag_c = 0;
  logic        out_valid, out_taken, out_notbr;
  logic [15:0] out_target;
  logic [2:0]  out_len;
  logic [3:0]  out_cycles;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  relbr_decode i_relbr_decode (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .in_addr(in_addr),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
    .out_valid(out_valid), .out_taken(out_taken), .out_target(out_target),
    .out_len(out_len), .out_cycles(out_cycles), .out_notbr(out_notbr)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic logic model_taken(input logic [7:0] op, input logic [3:0] f);
    logic n, z, v, c;
    {n, z, v, c} = f;
    case (op)
      8'h22: return !c && !z;
      8'h23: return c || z;
      8'h24: return !c;
      8'h25: return c;
      8'h26: return !z;
      8'h27: return z;
      8'h28: return !v;
      8'h29: return v;
      8'h2A: return !n;
      8'h2B: return n;
      8'h2C: return n == v;
      8'h2D: return n != v;
      8'h2E: return !z && (n == v);
      default: return z || (n != v);
    endcase
  endfunction

  task automatic set_flags(input logic [3:0] f);
    {flag_n, flag_z, flag_v, flag_c} = f;
  endtask

  // offer one byte; returns just after the edge that consumed it
  task automatic send(input logic [7:0] b, input logic [15:0] a);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_byte = b; in_addr = a;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic expect_result(input logic tk, input logic [15:0] tgt,
                               input logic [2:0] len, input logic [3:0] cyc, input string tag);
    @(negedge clk);
    chk(out_valid, 1, {tag, " valid pulse"});
    chk(out_notbr, 0, {tag, " no reject"});
    chk(in_ready, 0, {"R9 ready low during pulse ", tag});
    chk(out_taken, tk, {tag, " taken"});
    chk(out_target, tgt, {"R5 target ", tag});
    chk(out_len, len, {tag, " length"});
    chk(out_cycles, cyc, {tag, " cycles"});
    @(negedge clk);
    chk(out_valid, 0, {"R10 pulse ends ", tag});
  endtask

  task automatic run_short(input logic [7:0] op, input logic [7:0] off,
                           input logic [15:0] a, input logic [3:0] f, input string tag);
    logic [15:0] tgt;
    tgt = a + 16'd2 + {{8{off[7]}}, off};
    set_flags(f);
    send(op, a);
    send(off, a + 16'd1);
    expect_result(model_taken(op, f), tgt, 3'd2, 4'd3, tag);
  endtask

  task automatic run_long(input logic [7:0] op, input logic [15:0] off,
                          input logic [15:0] a, input logic [3:0] f, input string tag);
    logic tk;
    tk = model_taken(op, f);
    set_flags(f);
    send(8'h10, a);
    send(op, a + 16'd1);
    repeat (2) @(negedge clk);
    send(off[15:8], a + 16'd2);
    send(off[7:0], a + 16'd3);
    expect_result(tk, a + 16'd4 + off, 3'd4, tk ? 4'd6 : 4'd5, tag);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(out_valid, 0, "R1 reset valid");
    chk(out_notbr, 0, "R1 reset notbr");
    chk(in_ready, 1, "R1 reset ready");
  endtask

  task automatic t_all_conditions;
    for (int op = 8'h22; op <= 8'h2F; op++) begin
      for (int f = 0; f < 16; f++) begin
        run_short(8'(op), 8'h05, 16'h1000 + 16'(op), 4'(f),
                  (op >= 8'h2C) ? "R4 signed cond" : "R3 cond R2 short");
      end
    end
  endtask

  task automatic t_targets;
    run_short(8'h27, 8'hF0, 16'h2000, 4'b0100, "R5 backward");
    run_short(8'h27, 8'h7F, 16'hFFF0, 4'b0000, "R5 wrap not taken");
    run_short(8'h24, 8'h80, 16'h0010, 4'b0000, "R5 wrap backward");
  endtask

  task automatic t_long;
    run_long(8'h26, 16'h1234, 16'h3000, 4'b0000, "R6 R7 long taken");
    run_long(8'h26, 16'hFF00, 16'h3000, 4'b0100, "R6 R7 long not taken");
    run_long(8'h2E, 16'h8000, 16'h0100, 4'b0000, "R7 long gt");
    run_long(8'h2D, 16'h0003, 16'hFFFE, 4'b0000, "R6 long wrap");
  endtask

  task automatic t_reject;
    send(8'h12, 16'h4000);
    @(negedge clk);
    chk(out_notbr, 1, "R8 plain reject pulse");
    chk(out_valid, 0, "R8 no result on reject");
    @(negedge clk);
    chk(out_notbr, 0, "R8 reject single cycle");
    send(8'h10, 16'h4001);
    send(8'h86, 16'h4002);
    @(negedge clk);
    chk(out_notbr, 1, "R8 prefix reject pulse");
    chk(out_valid, 0, "R8 prefix no result");
    send(8'h20, 16'h4003);
    @(negedge clk);
    chk(out_notbr, 1, "R8 0x20 not a branch");
    run_short(8'h25, 8'h10, 16'h4100, 4'b0001, "R8 recover after reject");
  endtask

  task automatic t_backpressure;
    set_flags(4'b0100);
    send(8'h27, 16'h5000);
    send(8'h02, 16'h5001);
    in_valid = 1'b1; in_byte = 8'h26; in_addr = 16'h6000;
    @(negedge clk);
    chk(out_valid, 1, "R9 pulse with pending byte");
    chk(in_ready, 0, "R9 ready low while offered");
    @(posedge clk); #1;
    @(negedge clk);
    chk(out_valid, 0, "R9 no pulse when held byte taken");
    chk(in_ready, 1, "R9 ready back");
    @(posedge clk); #1;
    in_valid = 1'b0;
    send(8'h04, 16'h6001);
    expect_result(1'b0, 16'h6006, 3'd2, 4'd3, "R9 held opcode decoded");
  endtask

  task automatic t_flag_timing;
    set_flags(4'b0000);
    send(8'h27, 16'h7000);
    set_flags(4'b0100);
    send(8'h08, 16'h7001);
    expect_result(1'b1, 16'h700A, 3'd2, 4'd3, "R11 flags at offset");
    set_flags(4'b0100);
    send(8'h10, 16'h7100);
    send(8'h27, 16'h7101);
    send(8'h00, 16'h7102);
    set_flags(4'b0000);
    send(8'h10, 16'h7103);
    expect_result(1'b0, 16'h7114, 3'd4, 4'd5, "R11 long flags at last byte");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_all_conditions();
    t_targets();
    t_long();
    t_reject();
    t_backpressure();
    t_flag_timing();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule